// File: doc/BRIEF.md
# Complementary Dead-Zone Pair Generator

This block sits between a bank of PWM channels and their output stage. Channels are grouped in pairs. The even channel of a pair is the source. The odd channel is the partner. Each pair has its own enable. While a pair is enabled, the block ignores the partner's raw signal and drives both outputs from the source alone, as two opposite phases. A programmable gap separates the two phases, so that the two switches of a half-bridge are never on together.

The gap is an unsigned count of time units. The unit is the pair's timer tick: a one-cycle pulse on that pair's tick input, taken from the prescaled clock of that pair's timer. Cycles with the tick low do not shorten the gap. On each edge of the source, the phase that is turning off drops one clock later. The phase that is turning on waits until the gap count reaches zero. While a pair is disabled, each output of the pair follows its own raw channel, and that pair's gap counter is held at zero.

Top module: `dzp_top`

## Requirements
- R1: After reset the registered source copy of every pair is low and every gap counter is zero. With a pair enabled and its source held low, the even output reads 0 and the odd output reads 1.
- R2: While a pair's enable is 0, output 2p equals raw input 2p and output 2p+1 equals raw input 2p+1. The path is combinational, with no clock delay.
- R3: While a pair is enabled, its two outputs are never 1 at the same time.
- R4: While a pair is enabled, the output that a source edge turns off reads 0 from the first clock edge after the source change. For a rising source this is the odd output. For a falling source it is the even output.
- R5: The output that a source edge turns on rises after the clock edge on which the pair's tick has been seen high on N cycles, counted from the clock edge after the source change, where N is the pair's gap value. Cycles with tick low are not counted.
- R6: A gap of 0 gives a pure complementary pair. One clock after each source edge, the even output equals the source and the odd output equals its inverse.
- R7: A new source edge restarts the gap count. A source pulse shorter than the gap therefore leaves the output that would have turned on low for the whole pulse.
- R8: Clearing a pair's enable clears its gap counter. When the enable is set again with the source unchanged, the outputs are complementary at once, with no leftover gap.
- R9: Pairs are independent. One pair's enable, gap, tick and raw inputs have no effect on another pair's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dz_en | input | PAIRS | Per-pair enable for complementary mode |
| dz_gap | input | PAIRS*GAP_W | Per-pair gap length in ticks. Pair p uses bits [p*GAP_W +: GAP_W] |
| dz_tick | input | PAIRS | Per-pair time-unit pulse from the pair's prescaled timer clock |
| pwm_raw | input | 2*PAIRS | Raw channel signals. Bit 2p is the source of pair p. Bit 2p+1 is its partner |
| pwm_out | output | 2*PAIRS | Conditioned outputs. Bit 2p is the in-phase output. Bit 2p+1 is the inverted output |

## Verification
A gap counter stuck at a nonzero value shows at the ports as an enabled pair with both outputs low. A stale source copy shows as an output that stays high after its source edge. Either fault is visible one clock after the first source edge or re-enable that exercises it. A counter that decrements on untick'd cycles, or that is not reloaded by a new edge, shows up as an early rise. This can be seen in the cycle-exact sequences of gaps, short pulses and gated ticks.

// File: rtl/dzp_pkg.sv
package dzp_pkg;
  localparam int unsigned DZP_PAIRS = 2;
  localparam int unsigned DZP_GAP_W = 8;
endpackage

// File: rtl/dzp_rst_sync.sv
module dzp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dzp_gap_cnt.sv
module dzp_gap_cnt #(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             tick,
  output logic             busy
);
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign busy = (cnt_q != '0);

  // next-state: clear wins, then reload on edge, then tick-gated decrement
  always_comb begin
    cnt_d = cnt_q;
    if (clr)               cnt_d = '0;
    else if (load)         cnt_d = load_val;
    else if (tick && busy) cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = clr | load | (tick & busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dzp_pair.sv
module dzp_pair #(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [GAP_W-1:0] gap,
  input  logic             tick,
  input  logic             src,
  input  logic             partner,
  output logic             out_ph,
  output logic             out_nph
);
  logic src_q, src_d;
  logic src_edge;
  logic gap_busy;

  assign src_d    = src;
  assign src_edge = src ^ src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src_d;
  end

  dzp_gap_cnt #(.GAP_W(GAP_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (~en),
    .load     (en & src_edge),
    .load_val (gap),
    .tick     (tick),
    .busy     (gap_busy)
  );

  // outputs: each phase is on only when the gap count has run out
  always_comb begin
    if (en) begin
      out_ph  =  src_q & ~gap_busy;
      out_nph = ~src_q & ~gap_busy;
    end else begin
      out_ph  = src;
      out_nph = partner;
    end
  end
endmodule

// File: rtl/dzp_top.sv
module dzp_top
  import dzp_pkg::*;
#(
  parameter int unsigned PAIRS = DZP_PAIRS,
  parameter int unsigned GAP_W = DZP_GAP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PAIRS-1:0]       dz_en,
  input  logic [PAIRS*GAP_W-1:0] dz_gap,
  input  logic [PAIRS-1:0]       dz_tick,
  input  logic [2*PAIRS-1:0]     pwm_raw,
  output logic [2*PAIRS-1:0]     pwm_out
);
  localparam int unsigned CH = 2 * PAIRS;

  logic rst_int_n;
  logic [CH-1:0] out_w;

  dzp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    dzp_pair #(.GAP_W(GAP_W)) u_pair (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .en      (dz_en[p]),
      .gap     (dz_gap[p*GAP_W +: GAP_W]),
      .tick    (dz_tick[p]),
      .src     (pwm_raw[2*p]),
      .partner (pwm_raw[2*p+1]),
      .out_ph  (out_w[2*p]),
      .out_nph (out_w[2*p+1])
    );
  end

  assign pwm_out = out_w;
endmodule

// File: rtl/dzp_chk.sv
module dzp_chk #(
  parameter int unsigned PAIRS = 2,
  parameter int unsigned GAP_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [PAIRS-1:0]       dz_en,
  input logic [PAIRS*GAP_W-1:0] dz_gap,
  input logic [PAIRS-1:0]       dz_tick,
  input logic [2*PAIRS-1:0]     pwm_raw,
  input logic [2*PAIRS-1:0]     pwm_out
);
  for (genvar p = 0; p < PAIRS; p++) begin : g_chk
    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      !dz_en[p] |-> (pwm_out[2*p+1 -: 2] == pwm_raw[2*p+1 -: 2]));

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      dz_en[p] |-> !(pwm_out[2*p] && pwm_out[2*p+1]));

    a_r4_ph_off: assert property (@(posedge clk) disable iff (!rst_n)
      (dz_en[p] && $past(dz_en[p]) && !$past(pwm_raw[2*p])) |-> !pwm_out[2*p]);

    a_r4_nph_off: assert property (@(posedge clk) disable iff (!rst_n)
      (dz_en[p] && $past(dz_en[p]) && $past(pwm_raw[2*p])) |-> !pwm_out[2*p+1]);

    a_r6_zero_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (dz_en[p] && $past(dz_en[p]) && ($past(dz_gap[p*GAP_W +: GAP_W]) == '0)
       && ($past(pwm_raw[2*p]) != $past(pwm_raw[2*p], 2)))
      |-> (pwm_out[2*p] != pwm_out[2*p+1]));
  end
endmodule

bind dzp_top dzp_chk #(.PAIRS(PAIRS), .GAP_W(GAP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .dz_en   (dz_en),
  .dz_gap  (dz_gap),
  .dz_tick (dz_tick),
  .pwm_raw (pwm_raw),
  .pwm_out (pwm_out)
);

// File: tb/tb_dzp_top.sv
module tb_dzp_top;
  localparam int unsigned PAIRS = 2;
  localparam int unsigned GAP_W = 8;
  localparam int NVEC = 14;
  // each entry: {src, tick, exp_nph, exp_ph} for pair 0, gap 3
  localparam logic [3:0] VEC [NVEC] = '{
    4'b1100, 4'b1100, 4'b1000, 4'b1100, 4'b1101, 4'b1101, 4'b0100,
    4'b0100, 4'b1100, 4'b0100, 4'b0100, 4'b0100, 4'b0110, 4'b0110};

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [PAIRS-1:0]       dz_en;
  logic [PAIRS*GAP_W-1:0] dz_gap;
  logic [PAIRS-1:0]       dz_tick;
  logic [2*PAIRS-1:0]     pwm_raw;
  logic [2*PAIRS-1:0]     pwm_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  dzp_top #(.PAIRS(PAIRS), .GAP_W(GAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .dz_en(dz_en), .dz_gap(dz_gap),
    .dz_tick(dz_tick), .pwm_raw(pwm_raw), .pwm_out(pwm_out));

  always #4 clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dz_en = '0; dz_gap = '0; dz_tick = '0; pwm_raw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk("R1 reset bypass zero", pwm_out, 4'b0000);

    // R1: enable pair 0 after reset, source low
    dz_en = 2'b01; dz_gap[7:0] = 8'd3; dz_tick = 2'b11;
    pwm_raw = 4'b0100;
    cyc();
    chk("R1 enabled idle", {2'b00, pwm_out[1:0]}, 4'b0010);
    chk("R9 pair1 bypass", {2'b00, pwm_out[3:2]}, 4'b0001);

    // table: R4 R5 R7 R3 on pair 0
    for (int i = 0; i < NVEC; i++) begin
      pwm_raw[0] = VEC[i][3];
      dz_tick[0] = VEC[i][2];
      cyc();
      chk($sformatf("R4 R5 R7 R3 vec %0d", i), {2'b00, pwm_out[1:0]}, {2'b00, VEC[i][1:0]});
    end

    // R6: zero gap
    dz_gap[7:0] = 8'd0;
    pwm_raw[0] = 1'b1; cyc();
    chk("R6 zero gap rise", {2'b00, pwm_out[1:0]}, 4'b0001);
    pwm_raw[0] = 1'b0; cyc();
    chk("R6 zero gap fall", {2'b00, pwm_out[1:0]}, 4'b0010);

    // R8: disable mid-count, re-enable with no leftover gap
    dz_gap[7:0] = 8'd5;
    pwm_raw[1:0] = 2'b01; cyc();
    cyc();
    chk("R8 counting", {2'b00, pwm_out[1:0]}, 4'b0000);
    dz_en[0] = 1'b0; #1;
    chk("R2 bypass on disable", {2'b00, pwm_out[1:0]}, 4'b0001);
    @(negedge clk);
    dz_en[0] = 1'b1; #1;
    chk("R8 re-enable no gap", {2'b00, pwm_out[1:0]}, 4'b0001);
    @(negedge clk);

    // R2: both pairs bypass, each channel its own input
    dz_en = 2'b00;
    pwm_raw = 4'b1010; #1;
    chk("R2 bypass a", pwm_out, 4'b1010);
    pwm_raw = 4'b0110; #1;
    chk("R2 bypass b", pwm_out, 4'b0110);
    @(negedge clk);

    // R9: pair 1 with its own gap, pair 0 bypassed
    pwm_raw = 4'b0000; cyc();
    dz_en = 2'b10; dz_gap[15:8] = 8'd1; dz_tick = 2'b10;
    cyc();
    chk("R9 pair1 idle", pwm_out, 4'b1000);
    pwm_raw = 4'b0111; cyc();
    chk("R9 pair1 gap pair0 bypass", pwm_out, 4'b0011);
    cyc();
    chk("R9 R5 pair1 rises", pwm_out, 4'b0111);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule